// File: doc/BRIEF.md
# BCD Real-Time Clock Update Sequencer

This block runs the once-per-second advance of a calendar clock whose seven time bytes are kept in packed BCD. A one-hertz tick starts a cycle. Each cycle first raises an update-in-progress flag. It then waits a fixed number of fast-timebase ticks. After that wait it walks a carry chain one field per clock: seconds, minutes, hours, the day pair (weekday and date), month and year of century. A field that does not wrap ends the walk early.

When the walk ends, a single-cycle compare strobe tells the alarm matcher that the time bytes are stable. The update flag drops on the next clock. A software hold bit aborts any cycle in flight and keeps new cycles from starting, so the time can be loaded through the write port. Writes issued while the carry chain runs are dropped, because that is the window in which reads of the time bytes are not valid.

States and transitions:
- IDLE goes to LEAD on a tick, but only when the hold bit is clear and the divider control is not 000.
- LEAD goes to SEC once the fast-tick count reaches the lead parameter.
- SEC, MIN, HOUR, DAY and MON each step their own field. Each moves to the next state when its field wraps and to DONE when it does not.
- YEAR always moves to DONE.
- DONE pulses the strobe and returns to IDLE.
- From every state except IDLE, a set hold bit sends the machine to IDLE.

Top module: `rtc_tick_sequencer`

## Requirements
- R1: After reset the time is 00:00:00, weekday 01, date 01, month 01, year 00, and `uip`, `busy` and `alarm_cmp` are all low.
- R2: A `tick_1hz` pulse seen with `uip` low, `set_hold` low and `div_ctrl` not equal to 3'b000 raises `uip` on the next clock. A tick seen with `set_hold` high or with `div_ctrl` equal to 3'b000 leaves `uip` low and the time unchanged.
- R3: After `uip` rises, no time field changes until `LEAD_TICKS` cycles with `fast_tick` high have passed. With the default of 8 and `fast_tick` held high, `busy` rises 8 clocks after `uip` rises. Without fast ticks the block stays waiting with `uip` high.
- R4: Seconds step in BCD and wrap from 59 to 00. The wrap carries into minutes, which also wrap from 59 to 00 and carry into hours.
- R5: Hours wrap from 23 to 00. The wrap advances both the weekday (7 wraps to 1) and the date.
- R6: The date wraps to 01 after 31, after 30 for months 04, 06, 09 and 11, and after 28 for month 02, and this wrap carries into the month. The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R7: `alarm_cmp` is high for exactly one clock per completed update, after the last field has been written.
- R8: `uip` goes low on the clock after `alarm_cmp`.
- R9: `busy` is high only while `uip` is high, and covers the carry steps and the strobe cycle. A write presented while `busy` is high is ignored.
- R10: `set_hold` high while `uip` is high ends the cycle on the next clock with no strobe. An abort during the lead wait leaves the time unchanged.
- R11: With `busy` low, `wr_en` stores `wr_data` into the field chosen by `wr_sel`, where 0 selects seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month and 6 year. The value 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse each second |
| fast_tick | input | 1 | Fast timebase tick that paces the lead wait |
| set_hold | input | 1 | Hold bit: aborts and blocks updates |
| div_ctrl | input | 3 | Divider control; 3'b000 disables updates |
| wr_en | input | 1 | Time byte write strobe |
| wr_sel | input | 3 | Field select for writes (0..6) |
| wr_data | input | 8 | BCD write data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD (24-hour) |
| dow_o | output | 8 | Weekday, BCD 1..7 |
| date_o | output | 8 | Date of month, BCD |
| mon_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year of century, BCD |
| uip | output | 1 | Update in progress flag |
| busy | output | 1 | Carry chain active; reads invalid, writes dropped |
| alarm_cmp | output | 1 | Compare strobe to the alarm matcher |

## Verification
The bench drives the carry chain across its hardest joins. These are 23:59:59 on a seventh weekday at month end, the short February and 30-day month boundaries, and the full year rollover from 99. A design with a wrong month-length table, or one that loses the weekday carry, produces a calendar that the scoreboard rejects at the strobe. The bench also measures the lead wait in clocks, so an off-by-one counter shows up as a wrong count. It aborts with the hold bit during the lead, and it issues a write in the middle of an update and a write with the unused select. A design that let either of those writes through, or that still strobed after an abort, would alter time bytes or the strobe count that the bench reads back.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;

    localparam int NFIELD = 7;
    localparam int FW     = 8;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DOW  = 3;
    localparam int F_DATE = 4;
    localparam int F_MON  = 5;
    localparam int F_YEAR = 6;

    localparam logic [FW-1:0] FIELD_RST [NFIELD] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
    localparam logic [FW-1:0] FIELD_LO  [NFIELD] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
    localparam logic [FW-1:0] FIELD_HI  [NFIELD] = '{8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99};

    typedef enum logic [3:0] {
        S_IDLE,
        S_LEAD,
        S_SEC,
        S_MIN,
        S_HOUR,
        S_DAY,
        S_MON,
        S_YEAR,
        S_DONE
    } seq_state_t;

endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic [W-1:0] nxt,
    output logic         wrap
);
    localparam int ND = W / 4;

    logic [W-1:0] inc;
    logic [ND:0]  cy;

    always_comb begin
        cy[0] = 1'b1;
        for (int d = 0; d < ND; d++) begin
            if (cy[d] && val[d*4 +: 4] == 4'd9) begin
                inc[d*4 +: 4] = 4'd0;
                cy[d+1]       = 1'b1;
            end else begin
                inc[d*4 +: 4] = val[d*4 +: 4] + {3'b000, cy[d]};
                cy[d+1]       = 1'b0;
            end
        end
        wrap = (val == hi);
        nxt  = wrap ? lo : inc;
    end
endmodule

// File: rtl/rtc_month_days.sv
module rtc_month_days (
    input  logic [7:0] month,
    output logic [7:0] last_day
);
    always_comb begin
        unique case (month)
            8'h02:                      last_day = 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtc_lead_timer.sv
module rtc_lead_timer #(
    parameter int LEAD_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast_tick,
    output logic done
);
    localparam int CW = $clog2(LEAD_TICKS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (fast_tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && fast_tick && (cnt == CW'(LEAD_TICKS - 1));
endmodule

// File: rtl/rtc_tick_sequencer.sv
module rtc_tick_sequencer
    import rtc_seq_pkg::*;
#(
    parameter int LEAD_TICKS = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_1hz,
    input  logic         fast_tick,
    input  logic         set_hold,
    input  logic [2:0]   div_ctrl,
    input  logic         wr_en,
    input  logic [2:0]   wr_sel,
    input  logic [FW-1:0] wr_data,
    output logic [FW-1:0] sec_o,
    output logic [FW-1:0] min_o,
    output logic [FW-1:0] hour_o,
    output logic [FW-1:0] dow_o,
    output logic [FW-1:0] date_o,
    output logic [FW-1:0] mon_o,
    output logic [FW-1:0] year_o,
    output logic         uip,
    output logic         busy,
    output logic         alarm_cmp
);
    seq_state_t state, state_nxt;

    logic [FW-1:0] fld      [NFIELD];
    logic [FW-1:0] fld_hi   [NFIELD];
    logic [FW-1:0] fld_nxt  [NFIELD];
    logic [NFIELD-1:0] fld_wrap;
    logic [FW-1:0] month_last;
    logic          lead_done;
    logic          start_ok;

    rtc_lead_timer #(.LEAD_TICKS(LEAD_TICKS)) u_lead (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state == S_LEAD),
        .fast_tick (fast_tick),
        .done      (lead_done)
    );

    rtc_month_days u_mdays (
        .month    (fld[F_MON]),
        .last_day (month_last)
    );

    always_comb begin
        for (int i = 0; i < NFIELD; i++) begin
            fld_hi[i] = FIELD_HI[i];
        end
        fld_hi[F_DATE] = month_last;
    end

    for (genvar g = 0; g < NFIELD; g++) begin : g_step
        rtc_bcd_step #(.W(FW)) u_step (
            .val  (fld[g]),
            .lo   (FIELD_LO[g]),
            .hi   (fld_hi[g]),
            .nxt  (fld_nxt[g]),
            .wrap (fld_wrap[g])
        );
    end

    assign start_ok = tick_1hz && !set_hold && (div_ctrl != 3'b000);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        if (state != S_IDLE && set_hold) begin
            state_nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  state_nxt = start_ok ? S_LEAD : S_IDLE;
                S_LEAD:  state_nxt = lead_done ? S_SEC : S_LEAD;
                S_SEC:   state_nxt = fld_wrap[F_SEC]  ? S_MIN  : S_DONE;
                S_MIN:   state_nxt = fld_wrap[F_MIN]  ? S_HOUR : S_DONE;
                S_HOUR:  state_nxt = fld_wrap[F_HOUR] ? S_DAY  : S_DONE;
                S_DAY:   state_nxt = fld_wrap[F_DATE] ? S_MON  : S_DONE;
                S_MON:   state_nxt = fld_wrap[F_MON]  ? S_YEAR : S_DONE;
                S_YEAR:  state_nxt = S_DONE;
                S_DONE:  state_nxt = S_IDLE;
                default: state_nxt = S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        uip       = (state != S_IDLE);
        busy      = (state != S_IDLE) && (state != S_LEAD);
        alarm_cmp = (state == S_DONE);
    end

    // time byte storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NFIELD; i++) begin
                fld[i] <= FIELD_RST[i];
            end
        end else if (busy) begin
            if (!set_hold) begin
                unique case (state)
                    S_SEC:  fld[F_SEC]  <= fld_nxt[F_SEC];
                    S_MIN:  fld[F_MIN]  <= fld_nxt[F_MIN];
                    S_HOUR: fld[F_HOUR] <= fld_nxt[F_HOUR];
                    S_DAY: begin
                        fld[F_DOW]  <= fld_nxt[F_DOW];
                        fld[F_DATE] <= fld_nxt[F_DATE];
                    end
                    S_MON:  fld[F_MON]  <= fld_nxt[F_MON];
                    S_YEAR: fld[F_YEAR] <= fld_nxt[F_YEAR];
                    default: ;
                endcase
            end
        end else if (wr_en && wr_sel != 3'd7) begin
            fld[wr_sel] <= wr_data;
        end
    end

    assign sec_o  = fld[F_SEC];
    assign min_o  = fld[F_MIN];
    assign hour_o = fld[F_HOUR];
    assign dow_o  = fld[F_DOW];
    assign date_o = fld[F_DATE];
    assign mon_o  = fld[F_MON];
    assign year_o = fld[F_YEAR];
endmodule

// File: rtl/rtc_seq_checker.sv
module rtc_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_1hz,
    input logic       set_hold,
    input logic [2:0] div_ctrl,
    input logic       wr_en,
    input logic [7:0] sec_o,
    input logic       uip,
    input logic       busy,
    input logic       alarm_cmp
);
    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!uip && tick_1hz && !set_hold && div_ctrl != 3'b000) |=> uip);

    assert_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!uip && (set_hold || div_ctrl == 3'b000)) |=> !uip);

    assert_lead_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (uip && !busy && !wr_en) |=> $stable(sec_o));

    assert_sec_bcd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_o[3:0] <= 4'd9) && (sec_o <= 8'h59));

    assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_cmp |=> !alarm_cmp);

    assert_uip_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_cmp |=> !uip);

    assert_busy_in_uip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> uip);

    assert_hold_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (uip && set_hold) |=> (!uip && !alarm_cmp));
endmodule

bind rtc_tick_sequencer rtc_seq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1hz  (tick_1hz),
    .set_hold  (set_hold),
    .div_ctrl  (div_ctrl),
    .wr_en     (wr_en),
    .sec_o     (sec_o),
    .uip       (uip),
    .busy      (busy),
    .alarm_cmp (alarm_cmp)
);

// File: tb/sim_rtc_tick_sequencer.sv
module sim_rtc_tick_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int LEAD       = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       fast_tick = 1'b1;
    logic       set_hold = 1'b0;
    logic [2:0] div_ctrl = 3'b010;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, mon_o, year_o;
    logic       uip, busy, alarm_cmp;

    int checks = 0;
    int errors = 0;
    int stb_total = 0;
    logic prev_stb = 1'b0;
    logic [55:0] model;
    logic [55:0] expq [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_tick_sequencer #(.LEAD_TICKS(LEAD)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .fast_tick(fast_tick),
        .set_hold(set_hold), .div_ctrl(div_ctrl), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
        .dow_o(dow_o), .date_o(date_o), .mon_o(mon_o), .year_o(year_o),
        .uip(uip), .busy(busy), .alarm_cmp(alarm_cmp)
    );

    function automatic logic [55:0] now_t();
        return {year_o, mon_o, date_o, dow_o, hour_o, min_o, sec_o};
    endfunction

    function automatic int b2i(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2b(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int mlen(int m);
        if (m == 2) return 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [55:0] advance(logic [55:0] t);
        int s, mi, h, dw, dt, mo, y;
        s  = b2i(t[7:0]);   mi = b2i(t[15:8]);  h = b2i(t[23:16]);
        dw = b2i(t[31:24]); dt = b2i(t[39:32]); mo = b2i(t[47:40]); y = b2i(t[55:48]);
        s++;
        if (s == 60) begin
            s = 0; mi++;
            if (mi == 60) begin
                mi = 0; h++;
                if (h == 24) begin
                    h = 0;
                    dw = (dw == 7) ? 1 : dw + 1;
                    dt++;
                    if (dt > mlen(mo)) begin
                        dt = 1; mo++;
                        if (mo == 13) begin
                            mo = 1;
                            y = (y == 99) ? 0 : y + 1;
                        end
                    end
                end
            end
        end
        return {i2b(y), i2b(mo), i2b(dt), i2b(dw), i2b(h), i2b(mi), i2b(s)};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected snapshots at each compare strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stb) check("R8 uip after strobe", {63'd0, uip}, 64'd0);
            if (alarm_cmp) begin
                stb_total++;
                if (expq.size() == 0) begin
                    check("R7 unexpected strobe", 64'd1, 64'd0);
                end else begin
                    logic [55:0] e;
                    e = expq.pop_front();
                    check("R4 R5 R6 time at strobe", {8'd0, now_t()}, {8'd0, e});
                end
            end
            prev_stb <= alarm_cmp;
        end
    end

    task automatic wr(int sel, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(logic [55:0] t);
        for (int i = 0; i < 7; i++) wr(i, t[i*8 +: 8]);
        model = t;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (uip && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_update();
        model = advance(model);
        expq.push_back(model);
        do_tick();
        wait_idle();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset time", {8'd0, now_t()}, {8'd0, 56'h00_01_01_01_00_00_00});
        check("R1 reset flags", {61'd0, uip, busy, alarm_cmp}, 64'd0);
        model = now_t();

        // R4 plain seconds step, then R3 lead length
        run_update();
        check("R4 seconds 00->01", {56'd0, sec_o}, 64'h01);
        model = advance(model);
        expq.push_back(model);
        do_tick();
        check("R2 uip rises", {63'd0, uip}, 64'd1);
        n = 0;
        while (!busy && n < 50) begin
            @(negedge clk);
            n++;
        end
        check("R3 lead clocks", 64'(n), 64'(LEAD));
        wait_idle();
        @(negedge clk);

        // R3 no fast ticks: waits with uip high, no change
        fast_tick = 1'b0;
        do_tick();
        repeat (20) @(negedge clk);
        check("R3 held in lead", {62'd0, uip, busy}, 64'b10);
        check("R3 time untouched", {8'd0, now_t()}, {8'd0, model});
        model = advance(model);
        expq.push_back(model);
        fast_tick = 1'b1;
        wait_idle();
        @(negedge clk);

        // R4 minute carry
        load(56'h23_05_14_02_10_20_59);
        run_update();
        check("R4 min carry", {48'd0, min_o, sec_o}, 64'h2100);

        // R5 R6 day end at weekday 7, month 1 end
        load(56'h24_01_31_07_23_59_59);
        run_update();
        check("R5 weekday wrap", {56'd0, dow_o}, 64'h01);
        check("R6 jan->feb", {48'd0, mon_o, date_o}, 64'h0201);

        // R6 february and 30 day month
        load(56'h24_02_28_03_23_59_59);
        run_update();
        check("R6 feb end", {48'd0, mon_o, date_o}, 64'h0301);
        load(56'h24_04_30_03_23_59_59);
        run_update();
        check("R6 apr end", {48'd0, mon_o, date_o}, 64'h0501);
        load(56'h24_06_29_03_23_59_59);
        run_update();
        check("R6 jun 29 no wrap", {48'd0, mon_o, date_o}, 64'h0630);

        // R6 full rollover
        load(56'h99_12_31_06_23_59_59);
        run_update();
        check("R6 year wrap", {8'd0, now_t()}, {8'd0, 56'h00_01_01_07_00_00_00});

        // R2 ignored ticks
        s0 = stb_total;
        set_hold = 1'b1;
        do_tick();
        check("R2 hold blocks start", {63'd0, uip}, 64'd0);
        set_hold = 1'b0;
        div_ctrl = 3'b000;
        do_tick();
        check("R2 divider off blocks", {63'd0, uip}, 64'd0);
        div_ctrl = 3'b010;
        repeat (LEAD + 4) @(negedge clk);
        check("R2 time unchanged", {8'd0, now_t()}, {8'd0, model});

        // R9 write during busy is dropped
        load(56'h10_03_03_03_03_03_10);
        model = advance(model);
        expq.push_back(model);
        do_tick();
        n = 0;
        while (!busy && n < 50) begin
            @(negedge clk);
            n++;
        end
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h45;
        @(negedge clk);
        wr_en = 1'b0;
        wait_idle();
        @(negedge clk);
        check("R9 busy write ignored", {56'd0, sec_o}, 64'h11);

        // R10 abort in lead
        s0 = stb_total;
        do_tick();
        repeat (3) @(negedge clk);
        set_hold = 1'b1;
        @(negedge clk);
        check("R10 abort drops uip", {63'd0, uip}, 64'd0);
        set_hold = 1'b0;
        repeat (LEAD + 4) @(negedge clk);
        check("R10 no strobe", 64'(stb_total), 64'(s0));
        check("R10 time kept", {8'd0, now_t()}, {8'd0, model});

        // R11 writes
        wr(3, 8'h05);
        check("R11 weekday write", {56'd0, dow_o}, 64'h05);
        model[31:24] = 8'h05;
        wr(7, 8'h33);
        check("R11 select 7 ignored", {8'd0, now_t()}, {8'd0, model});

        // R7 one strobe per update
        s0 = stb_total;
        run_update();
        check("R7 single strobe", 64'(stb_total), 64'(s0 + 1));
        check("R7 queue drained", 64'(expq.size()), 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule